// File: doc/BRIEF.md
# Clock Post-Divider Output Stage

This block is the digital back end of a frequency synthesizer. It chooses the clock that feeds an integer post-divider: either the fast oscillator clock or, when the loop is bypassed, one of two reference clocks. It then divides that clock by 4, 5 or 10 according to a 2-bit ratio code. The divided clock fans out to four identical single-ended outputs. These outputs can be held low by a master reset or released to high impedance by an output enable.

The ratio code and the reset are brought into the divider clock domain through synchronizer stages. A new ratio is adopted only when the divider counter wraps, so a ratio change never creates a runt pulse. The odd ratio uses a half-cycle-delayed copy of the counter output, which keeps its duty cycle at 50 percent.

Top module: `clk_post_divider`

## Requirements
- R1: The ratio code sets the divisor as follows: 2'b00 gives 4, 2'b01 gives 5, 2'b10 gives 10 and 2'b11 gives 5. The output period equals the divisor times the period of the divider source clock.
- R2: For every code, the output high time equals exactly half of the output period, including the odd divisor 5.
- R3: When `bypass` is 0 the divider source is `vco_clk`. When `bypass` is 1 the divider source is the reference picked under R4.
- R4: The reference is `xtal_clk` when `ref_sel` is 0 and `ext_ref_clk` when `ref_sel` is 1.
- R5: After `mrst` rises, every output reads 0 within four source periods and stays 0 while `mrst` stays high and `oe` is 1.
- R6: `mrst` is released through two source-clock synchronizer edges. The first output rising edge then follows floor(divisor/2) source periods later. Odd divisors add half a source period.
- R7: When `oe` is 0 all four outputs are undriven (high impedance), whether or not `mrst` is high.
- R8: All four outputs carry the same waveform at all times.
- R9: A change of the ratio code takes effect only at a counter wrap. No high or low phase is ever shorter than half of the shorter of the old and new periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast oscillator clock, divider source when not bypassed |
| xtal_clk | input | 1 | Crystal-path reference clock |
| ext_ref_clk | input | 1 | External reference clock |
| ref_sel | input | 1 | Reference pick: 0 crystal path, 1 external |
| bypass | input | 1 | 1 feeds the reference straight to the divider |
| div_sel | input | 2 | Ratio code (see R1) |
| mrst | input | 1 | Active-high master reset, outputs forced low |
| oe | input | 1 | Output enable, 0 releases the outputs |
| clk_out | output | NUM_OUTS | Divided clock outputs |

## Verification
Reset assertion and release each pass through two synchronizer edges of the source clock before the counter reacts. The bench therefore changes `mrst` one nanosecond after a source rising edge and predicts the first output edge to the exact source edge. For a divisor of 4, that edge comes 15 ns after release with a 4 ns oscillator period; a divisor of 5 adds a further 2 ns. Period and high time are measured between output edges only after several full output periods have passed since the setup change. Each level check samples 0.1 ns after an output edge, or in the middle of long windows, and never on a clock edge. After a ratio change, every phase width is recorded across enough edges to cover the synchronizer delay, the wait for the wrap, and several periods at the new ratio.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int unsigned DIV_W = 4;

  typedef logic [1:0]       div_code_t;
  typedef logic [DIV_W-1:0] div_val_t;

  // Ratio code to divisor; two codes share the odd divisor.
  function automatic div_val_t code_to_div(input div_code_t code);
    case (code)
      2'b00:   code_to_div = div_val_t'(4);
      2'b01:   code_to_div = div_val_t'(5);
      2'b10:   code_to_div = div_val_t'(10);
      default: code_to_div = div_val_t'(5);
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_sync.sv
`timescale 1ns/1ps
module clkdiv_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= d;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) stg[i] <= stg[i-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clkdiv_src_mux.sv
`timescale 1ns/1ps
module clkdiv_src_mux (
  input  logic vco_clk,
  input  logic xtal_clk,
  input  logic ext_ref_clk,
  input  logic ref_sel,
  input  logic bypass,
  output logic div_clk
);
  logic ref_clk;

  assign ref_clk = ref_sel ? ext_ref_clk : xtal_clk;
  assign div_clk = bypass  ? ref_clk     : vco_clk;
endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic      div_clk,
  input  logic      rst_s,
  input  div_code_t code_s,
  output logic      div_q,
  output div_val_t  cnt_o,
  output div_val_t  act_o
);
  div_val_t cnt_q, cnt_n;
  div_val_t act_q, act_n;
  logic     pos_q, pos_n;
  logic     neg_q;
  logic     wrap;

  always_comb begin
    wrap  = (cnt_q == act_q - 1'b1);
    cnt_n = wrap ? '0 : cnt_q + 1'b1;
    act_n = wrap ? code_to_div(code_s) : act_q;
    // Low phase first: output rises once the count reaches floor(div/2).
    pos_n = (cnt_n >= (act_n >> 1));
  end

  always_ff @(posedge div_clk) begin
    if (rst_s) begin
      cnt_q <= '0;
      act_q <= code_to_div(code_s);
      pos_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      act_q <= act_n;
      pos_q <= pos_n;
    end
  end

  // Half-cycle-delayed copy, used to trim the odd high phase to 50 percent.
  always_ff @(negedge div_clk) begin
    if (rst_s) neg_q <= 1'b0;
    else       neg_q <= pos_q;
  end

  assign div_q = act_q[0] ? (pos_q & neg_q) : pos_q;
  assign cnt_o = cnt_q;
  assign act_o = act_q;
endmodule

// File: rtl/clk_post_divider.sv
`timescale 1ns/1ps
module clk_post_divider
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUTS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                vco_clk,
  input  logic                xtal_clk,
  input  logic                ext_ref_clk,
  input  logic                ref_sel,
  input  logic                bypass,
  input  logic [1:0]          div_sel,
  input  logic                mrst,
  input  logic                oe,
  output logic [NUM_OUTS-1:0] clk_out
);
  logic      div_clk;
  logic      rst_s;
  div_code_t code_s;
  logic      div_q;
  div_val_t  cnt_w;
  div_val_t  act_w;

  clkdiv_src_mux u_mux (
    .vco_clk    (vco_clk),
    .xtal_clk   (xtal_clk),
    .ext_ref_clk(ext_ref_clk),
    .ref_sel    (ref_sel),
    .bypass     (bypass),
    .div_clk    (div_clk)
  );

  clkdiv_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(div_clk), .d(mrst), .q(rst_s)
  );

  clkdiv_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sel_sync (
    .clk(div_clk), .d(div_sel), .q(code_s)
  );

  clkdiv_core u_core (
    .div_clk(div_clk),
    .rst_s  (rst_s),
    .code_s (code_s),
    .div_q  (div_q),
    .cnt_o  (cnt_w),
    .act_o  (act_w)
  );

  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_out
    assign clk_out[i] = oe ? div_q : 1'bz;
  end
endmodule

// File: rtl/clk_post_divider_chk.sv
`timescale 1ns/1ps
module clk_post_divider_chk
  import clkdiv_pkg::*;
(
  input logic     div_clk,
  input logic     rst_s,
  input div_val_t cnt,
  input div_val_t act_div,
  input logic     div_q
);
  logic seen_rst = 1'b0;

  always_ff @(posedge div_clk) seen_rst <= seen_rst | rst_s;

  // R5: a synchronized reset has forced the divided clock low by the next edge
  a_r5_reset_forces_low: assert property (@(posedge div_clk) disable iff (!seen_rst)
    rst_s |=> !div_q);

  // R1: only the three legal divisors are ever active
  a_r1_divisor_legal: assert property (@(posedge div_clk) disable iff (rst_s || !seen_rst)
    (act_div == 4) || (act_div == 5) || (act_div == 10));

  // R2: the counter stays inside the active divisor
  a_r2_count_in_range: assert property (@(posedge div_clk) disable iff (rst_s || !seen_rst)
    cnt < act_div);

  // R9: the ratio cannot move except at the wrap point
  a_r9_ratio_held_mid_period: assert property (@(posedge div_clk) disable iff (rst_s || !seen_rst)
    (cnt != 0) |-> $stable(act_div));

  // R9: the last count is followed by zero
  a_r9_wrap_to_zero: assert property (@(posedge div_clk) disable iff (rst_s || !seen_rst)
    (cnt == act_div - 1'b1) |=> (cnt == 0));
endmodule

bind clk_post_divider clk_post_divider_chk u_chk (
  .div_clk(div_clk),
  .rst_s  (rst_s),
  .cnt    (cnt_w),
  .act_div(act_w),
  .div_q  (div_q)
);

// File: tb/clk_post_divider_test.sv
`timescale 1ns/1ps
module clk_post_divider_test;
  localparam real VCO_PERIOD  = 4.0;
  localparam real XTAL_PERIOD = 10.0;
  localparam real EXT_PERIOD  = 14.0;
  localparam real TOL         = 0.05;
  localparam int  SYNC        = 2;

  logic       vco_clk = 1'b0;
  logic       xtal_clk = 1'b0;
  logic       ext_ref_clk = 1'b0;
  logic       ref_sel = 1'b0;
  logic       bypass = 1'b0;
  logic [1:0] div_sel = 2'b11;
  logic       mrst = 1'b1;
  logic       oe = 1'b1;
  wire  [3:0] q_bus;

  int checks = 0;
  int fails  = 0;

  pullup (q_bus[0]);
  pullup (q_bus[1]);
  pullup (q_bus[2]);
  pullup (q_bus[3]);

  always #(VCO_PERIOD/2.0)  vco_clk     = ~vco_clk;
  always #(XTAL_PERIOD/2.0) xtal_clk    = ~xtal_clk;
  always #(EXT_PERIOD/2.0)  ext_ref_clk = ~ext_ref_clk;

  clk_post_divider uut (
    .vco_clk    (vco_clk),
    .xtal_clk   (xtal_clk),
    .ext_ref_clk(ext_ref_clk),
    .ref_sel    (ref_sel),
    .bypass     (bypass),
    .div_sel    (div_sel),
    .mrst       (mrst),
    .oe         (oe),
    .clk_out    (q_bus)
  );

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic chk_real(input string req, input string what, input real act, input real exp);
    checks++;
    if ((act - exp > TOL) || (exp - act > TOL)) begin
      fails++;
      $display("FAIL %s %s: actual=%0.3f expected=%0.3f", req, what, act, exp);
    end
  endtask

  task automatic chk_bits(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // R1 R2 R3 R4 R8: one operating mode, measured after a reset and a settle time
  task automatic run_mode(input logic [1:0] code, input logic byp, input logic rsel,
                          input real src_per, input int div, input string req);
    real t0, t1, t2;
    div_sel = code; bypass = byp; ref_sel = rsel; oe = 1'b1;
    mrst = 1'b1;
    #(src_per * 8.0);
    mrst = 1'b0;
    #(src_per * div * 4.0);
    @(posedge q_bus[0]); t0 = $realtime;
    #0.1 chk_bits("R8", "outputs after rise", q_bus, 4'b1111);
    @(negedge q_bus[0]); t1 = $realtime;
    #0.1 chk_bits("R8", "outputs after fall", q_bus, 4'b0000);
    @(posedge q_bus[0]); t2 = $realtime;
    chk_real(req, "period", t2 - t0, src_per * div);
    chk_real("R2", "high time", t1 - t0, src_per * div / 2.0);
  endtask

  // R5 R7: reset holds low; disable releases the lines to the pull-ups
  task automatic reset_and_enable();
    logic [3:0] seen_or;
    div_sel = 2'b00; bypass = 1'b0; oe = 1'b1; mrst = 1'b0;
    #(VCO_PERIOD * 40.0);
    @(posedge vco_clk); #1.0; mrst = 1'b1;
    #(VCO_PERIOD * 4.0);
    seen_or = 4'b0000;
    for (int i = 0; i < 20; i++) begin
      #1.3 seen_or = seen_or | q_bus;
    end
    chk_bits("R5", "outputs held in reset", seen_or, 4'b0000);
    oe = 1'b0;
    #1.0 chk_bits("R7", "disabled during reset", q_bus, 4'b1111);
    mrst = 1'b0;
    seen_or = 4'b1111;
    for (int i = 0; i < 40; i++) begin
      #1.3 seen_or = seen_or & q_bus;
    end
    chk_bits("R7", "disabled while running", seen_or, 4'b1111);
    oe = 1'b1;
  endtask

  // R6: first rising edge after reset release
  task automatic release_timing(input logic [1:0] code, input int div);
    real trel, exp;
    div_sel = code; bypass = 1'b0; oe = 1'b1; mrst = 1'b1;
    #(VCO_PERIOD * 10.0);
    @(posedge vco_clk); #1.0; mrst = 1'b0; trel = $realtime;
    @(posedge q_bus[0]);
    exp = (SYNC + div / 2) * VCO_PERIOD - 1.0 + ((div % 2) != 0 ? VCO_PERIOD / 2.0 : 0.0);
    chk_real("R6", "release to first rise", $realtime - trel, exp);
  endtask

  // R9: switch from ratio 10 to ratio 4 while running
  task automatic ratio_switch();
    real prev, w, wmin, wlast;
    div_sel = 2'b10; bypass = 1'b0; oe = 1'b1; mrst = 1'b1;
    #(VCO_PERIOD * 8.0);
    mrst = 1'b0;
    #(VCO_PERIOD * 60.0);
    @(posedge q_bus[0]); #3.0; div_sel = 2'b00;
    @(q_bus[0]); prev = $realtime;
    wmin = 1.0e9; wlast = 0.0;
    for (int i = 0; i < 16; i++) begin
      @(q_bus[0]);
      w = $realtime - prev; prev = $realtime;
      if (w < wmin) wmin = w;
      wlast = w;
    end
    chk_real("R9", "shortest phase across switch", wmin, VCO_PERIOD * 2.0);
    chk_real("R9", "phase at new ratio", wlast, VCO_PERIOD * 2.0);
  endtask

  initial begin
    #(VCO_PERIOD * 3.0);
    chk_bits("R5", "outputs during power-up reset", q_bus, 4'b0000);
    run_mode(2'b00, 1'b0, 1'b0, VCO_PERIOD, 4,  "R1");
    run_mode(2'b01, 1'b0, 1'b0, VCO_PERIOD, 5,  "R1");
    run_mode(2'b10, 1'b0, 1'b0, VCO_PERIOD, 10, "R1");
    run_mode(2'b11, 1'b0, 1'b0, VCO_PERIOD, 5,  "R1");
    run_mode(2'b00, 1'b1, 1'b0, XTAL_PERIOD, 4, "R3");
    run_mode(2'b10, 1'b1, 1'b0, XTAL_PERIOD, 10, "R4");
    run_mode(2'b01, 1'b1, 1'b1, EXT_PERIOD, 5,  "R4");
    run_mode(2'b11, 1'b1, 1'b1, EXT_PERIOD, 5,  "R3");
    reset_and_enable();
    release_timing(2'b00, 4);
    release_timing(2'b01, 5);
    ratio_switch();
    report();
    $finish;
  end

  initial begin
    #200000.0;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
    $finish;
  end
endmodule